// File: doc/BRIEF.md
# Integer ALU with Condition Codes

This block is the integer execute stage of a 32-bit core. It takes an operation code, a first operand and a second operand, and returns the result in the same cycle. The second operand is either a register value or a sign-extended immediate, picked by a select bit. Each arithmetic and logical operation has a twin that also writes four condition flags into a small register: negative, zero, overflow and carry. The stored carry flag feeds back as the carry-in of the add-with-carry operation.

The result path is purely combinational. The flag register is the only state, and it changes on a rising clock edge only when a valid flag-setting operation is presented. An undefined code raises an illegal-operation output while it is presented, and it leaves the flags untouched.

Top module: `alu_cc_top`

## Requirements
- R1: With flag setting off, the code selects the result. 0x00 gives A+B, 0x01 gives A&B, 0x02 gives A|B and 0x03 gives A^B. 0x04 gives A-B, 0x05 gives A&~B, 0x06 gives A|~B, 0x07 gives A^~B and 0x08 gives A+B+Cstored. The result is valid in the same cycle.
- R2: Codes 0x10 to 0x18 give the same results as 0x00 to 0x08. At the next rising edge they load N with result bit 31 and Z with (result == 0).
- R3: When immSel is 1, operand B is imm sign-extended from 13 to 32 bits. Otherwise operand B is regB.
- R4: For the add-type flag-setting codes (0x10 and 0x18), V = (a31&b31&~r31)|(~a31&~b31&r31) and C = (a31&b31)|(~r31&(a31|b31)).
- R5: For the subtract flag-setting code (0x14), V = (a31&~b31&~r31)|(~a31&b31&r31) and C = (~a31&b31)|(r31&(~a31|b31)).
- R6: The flag-setting logical codes (0x11, 0x12, 0x13, 0x15, 0x16, 0x17) always clear V and C.
- R7: Add-with-carry adds 1 to operand B when the stored C is 1. Code 0x18 computes V and C using the sign bit of that incremented B.
- R8: Code 0x25 shifts A left logically, 0x26 shifts A right logically and 0x27 shifts A right arithmetically, filling with A bit 31. The shift count is operand B bits [4:0]. Shifts never change the flags.
- R9: Every other code is undefined. For an undefined code, illegalOp is 1 in the same cycle while opValid is 1, and the flags keep their value across the edge.
- R10: Flags reset to all zero on rstN low. With opValid low they never change.
- R11: illegalOp is 0 whenever opValid is 0, and 0 for every defined code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 6 | Operation code; bit 4 selects flag setting |
| immSel | input | 1 | 1 selects the immediate as operand B |
| opA | input | 32 | First operand |
| regB | input | 32 | Register-sourced second operand |
| imm | input | 13 | Signed immediate |
| result | output | 32 | Combinational result |
| flagN | output | 1 | Stored negative flag |
| flagZ | output | 1 | Stored zero flag |
| flagV | output | 1 | Stored overflow flag |
| flagC | output | 1 | Stored carry/borrow flag |
| illegalOp | output | 1 | Undefined code presented while valid |

## Verification
The only internal state is the four-bit flag register. A wrong value there shows on the flag outputs one edge after the operation that wrote it. A wrong stored carry also corrupts the result of the next add-with-carry in the same cycle it is presented. For this reason, carry-sensitive tests chain a flag-setting add into an add-with-carry and check both the flags and that following result. The bench also checks that an undefined code, an invalid cycle and a shift each leave a known flag pattern unchanged, read back at the flag ports after the edge.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  localparam int OPC_W = 6;
  localparam logic [OPC_W-1:0] CODE_SLL = 6'h25;
  localparam logic [OPC_W-1:0] CODE_SRL = 6'h26;
  localparam logic [OPC_W-1:0] CODE_SRA = 6'h27;

  typedef enum logic [2:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_SLL, K_SRL, K_SRA
  } opKind_e;

  typedef struct packed {
    opKind_e kind;
    logic    invB;
    logic    addCarry;
    logic    flagWr;
    logic    logicFlags;
    logic    illegal;
  } aluStrobe_t;
endpackage

// File: rtl/alu_cc_ctrl.sv
module alu_cc_ctrl
  import alu_cc_pkg::*;
(
  input  logic             opValid,
  input  logic [OPC_W-1:0] opCode,
  output aluStrobe_t       strobe
);
  logic known;
  logic ccForm;
  logic logical;

  always_comb begin
    strobe.kind     = K_ADD;
    strobe.invB     = 1'b0;
    strobe.addCarry = 1'b0;
    known   = 1'b0;
    ccForm  = 1'b0;
    logical = 1'b0;
    if (!opCode[5] && (opCode[3:0] <= 4'd8)) begin
      known  = 1'b1;
      ccForm = opCode[4];
      case (opCode[3:0])
        4'd0: strobe.kind = K_ADD;
        4'd1: begin strobe.kind = K_AND; logical = 1'b1; end
        4'd2: begin strobe.kind = K_OR;  logical = 1'b1; end
        4'd3: begin strobe.kind = K_XOR; logical = 1'b1; end
        4'd4: strobe.kind = K_SUB;
        4'd5: begin strobe.kind = K_AND; strobe.invB = 1'b1; logical = 1'b1; end
        4'd6: begin strobe.kind = K_OR;  strobe.invB = 1'b1; logical = 1'b1; end
        4'd7: begin strobe.kind = K_XOR; strobe.invB = 1'b1; logical = 1'b1; end
        default: begin strobe.kind = K_ADD; strobe.addCarry = 1'b1; end
      endcase
    end else if (opCode == CODE_SLL) begin
      known = 1'b1; strobe.kind = K_SLL;
    end else if (opCode == CODE_SRL) begin
      known = 1'b1; strobe.kind = K_SRL;
    end else if (opCode == CODE_SRA) begin
      known = 1'b1; strobe.kind = K_SRA;
    end
    strobe.flagWr     = opValid & known & ccForm;
    strobe.logicFlags = logical;
    strobe.illegal    = opValid & ~known;
  end
endmodule

// File: rtl/alu_cc_datapath.sv
module alu_cc_datapath
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluStrobe_t       strobe,
  input  logic             immSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] regB,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags
);
  localparam int SH_W = $clog2(WIDTH);
  localparam int MSB  = WIDTH - 1;

  logic [WIDTH-1:0] bOp, bAdd, bLog;
  logic [SH_W-1:0]  shAmt;
  logic [3:0]       flagsNext;
  logic             aS, bS, rS, vNext, cNext;

  assign bOp   = immSel ? {{(WIDTH-IMM_W){imm[IMM_W-1]}}, imm} : regB;
  assign bAdd  = bOp + {{(WIDTH-1){1'b0}}, strobe.addCarry & flags[0]};
  assign bLog  = strobe.invB ? ~bOp : bOp;
  assign shAmt = bOp[SH_W-1:0];

  always_comb begin
    case (strobe.kind)
      K_ADD:   result = opA + bAdd;
      K_SUB:   result = opA - bOp;
      K_AND:   result = opA & bLog;
      K_OR:    result = opA | bLog;
      K_XOR:   result = opA ^ bLog;
      K_SLL:   result = opA << shAmt;
      K_SRL:   result = opA >> shAmt;
      default: result = $unsigned($signed(opA) >>> shAmt);
    endcase
  end

  always_comb begin
    aS = opA[MSB];
    rS = result[MSB];
    bS = (strobe.kind == K_SUB) ? bOp[MSB] : bAdd[MSB];
    if (strobe.logicFlags) begin
      vNext = 1'b0;
      cNext = 1'b0;
    end else if (strobe.kind == K_SUB) begin
      vNext = (aS & ~bS & ~rS) | (~aS & bS & rS);
      cNext = (~aS & bS) | (rS & (~aS | bS));
    end else begin
      vNext = (aS & bS & ~rS) | (~aS & ~bS & rS);
      cNext = (aS & bS) | (~rS & (aS | bS));
    end
    flagsNext = {rS, (result == '0), vNext, cNext};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              flags <= 4'b0000;
    else if (strobe.flagWr) flags <= flagsNext;
  end
endmodule

// File: rtl/alu_cc_top.sv
module alu_cc_top
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [5:0]       opCode,
  input  logic             immSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] regB,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagV,
  output logic             flagC,
  output logic             illegalOp
);
  aluStrobe_t strobe;
  logic [3:0] flags;

  alu_cc_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobe  (strobe)
  );

  alu_cc_datapath #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .immSel (immSel),
    .opA    (opA),
    .regB   (regB),
    .imm    (imm),
    .result (result),
    .flags  (flags)
  );

  assign {flagN, flagZ, flagV, flagC} = flags;
  assign illegalOp = strobe.illegal;
endmodule

// File: rtl/alu_cc_chk.sv
module alu_cc_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [5:0]       opCode,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] result,
  input logic             flagN,
  input logic             flagZ,
  input logic             flagV,
  input logic             flagC,
  input logic             illegalOp
);
  logic isCc, isLogicCc;
  assign isCc = (opCode[5:4] == 2'b01) && (opCode[3:0] <= 4'd8);
  assign isLogicCc = isCc && (opCode[3:0] != 4'd0) && (opCode[3:0] != 4'd4)
                     && (opCode[3:0] != 4'd8);

  assert_illegal_needs_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> opValid);

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && isCc) |=> $stable({flagN, flagZ, flagV, flagC}));

  assert_nz_update_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isCc) |=> (flagZ == ($past(result) == '0)) && (flagN == $past(result[WIDTH-1])));

  assert_logic_clears_vc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isLogicCc) |=> (!flagV && !flagC));

  assert_sra_sign_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 6'h27 && opA[WIDTH-1]) |-> result[WIDTH-1]);
endmodule

bind alu_cc_top alu_cc_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opA(opA),
  .result(result), .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC),
  .illegalOp(illegalOp)
);

// File: tb/sim_alu_cc_top.sv
`timescale 1ns/1ps
module sim_alu_cc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [5:0]  opCode = '0;
  logic        immSel = 1'b0;
  logic [31:0] opA = '0, regB = '0;
  logic [12:0] imm = '0;
  logic [31:0] result;
  logic        flagN, flagZ, flagV, flagC, illegalOp;

  int nChecks = 0;
  int nFail = 0;
  logic [3:0] curF = 4'b0000;

  always #10 clk = ~clk;

  alu_cc_top u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .immSel(immSel),
    .opA(opA), .regB(regB), .imm(imm), .result(result), .flagN(flagN),
    .flagZ(flagZ), .flagV(flagV), .flagC(flagC), .illegalOp(illegalOp)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Flags are {N,Z,V,C}; result sampled mid-cycle, flags after the edge.
  task automatic runOp(string tag, logic [5:0] code, logic [31:0] a, logic [31:0] b,
                       logic useImm, logic [12:0] im, logic [31:0] expR, logic [3:0] expF);
    @(negedge clk);
    opValid = 1'b1; opCode = code; opA = a; regB = b; immSel = useImm; imm = im;
    #5;
    chk({tag, " result"}, result, expR);
    chk({tag, " illegalOp low R11"}, {31'b0, illegalOp}, 32'h0);
    @(negedge clk);
    opValid = 1'b0;
    chk({tag, " flags"}, {28'b0, flagN, flagZ, flagV, flagC}, {28'b0, expF});
    curF = expF;
  endtask

  task automatic testReset();
    chk("R10 flags after reset", {28'b0, flagN, flagZ, flagV, flagC}, 32'h0);
    chk("R11 illegal in reset", {31'b0, illegalOp}, 32'h0);
  endtask

  task automatic testLogicPlain();
    logic [31:0] pa [3] = '{32'hF0F0_1234, 32'h0000_0000, 32'hFFFF_FFFF};
    logic [31:0] pb [3] = '{32'h0FF0_5555, 32'hA5A5_A5A5, 32'h1357_9BDF};
    for (int i = 0; i < 3; i++) begin
      runOp("R1 and",  6'h01, pa[i], pb[i], 1'b0, '0, pa[i] & pb[i], curF);
      runOp("R1 or",   6'h02, pa[i], pb[i], 1'b0, '0, pa[i] | pb[i], curF);
      runOp("R1 xor",  6'h03, pa[i], pb[i], 1'b0, '0, pa[i] ^ pb[i], curF);
      runOp("R1 andn", 6'h05, pa[i], pb[i], 1'b0, '0, pa[i] & ~pb[i], curF);
      runOp("R1 orn",  6'h06, pa[i], pb[i], 1'b0, '0, pa[i] | ~pb[i], curF);
      runOp("R1 xnor", 6'h07, pa[i], pb[i], 1'b0, '0, ~(pa[i] ^ pb[i]), curF);
      runOp("R1 add",  6'h00, pa[i], pb[i], 1'b0, '0, pa[i] + pb[i], curF);
      runOp("R1 sub",  6'h04, pa[i], pb[i], 1'b0, '0, pa[i] - pb[i], curF);
    end
  endtask

  task automatic testAddFlags();
    runOp("R4 addcc signed overflow", 6'h10, 32'h7FFF_FFFF, 32'h1, 1'b0, '0, 32'h8000_0000, 4'b1010);
    runOp("R4 addcc carry to zero",   6'h10, 32'hFFFF_FFFF, 32'h1, 1'b0, '0, 32'h0, 4'b0101);
  endtask

  task automatic testAddx();
    runOp("R7 addx with C set",   6'h08, 32'd10, 32'd20, 1'b0, '0, 32'd31, 4'b0101);
    runOp("R7 addxcc incremented B", 6'h18, 32'h1, 32'hFFFF_FFFF, 1'b0, '0, 32'h1, 4'b0000);
    runOp("R7 addx with C clear", 6'h08, 32'd10, 32'd20, 1'b0, '0, 32'd30, 4'b0000);
  endtask

  task automatic testSubFlags();
    runOp("R5 subcc borrow",   6'h14, 32'h0, 32'h1, 1'b0, '0, 32'hFFFF_FFFF, 4'b1001);
    runOp("R5 subcc overflow", 6'h14, 32'h8000_0000, 32'h1, 1'b0, '0, 32'h7FFF_FFFF, 4'b0010);
    runOp("R5 subcc zero",     6'h14, 32'd5, 32'd5, 1'b0, '0, 32'h0, 4'b0100);
    runOp("R2 plain sub keeps flags", 6'h04, 32'd3, 32'd5, 1'b0, '0, 32'hFFFF_FFFE, 4'b0100);
  endtask

  task automatic testImm();
    runOp("R3 imm minus one", 6'h00, 32'd5, 32'hDEAD_BEEF, 1'b1, 13'h1FFF, 32'd4, curF);
    runOp("R3 imm positive max cc", 6'h10, 32'd1, 32'hDEAD_BEEF, 1'b1, 13'h0FFF, 32'h1000, 4'b0000);
    runOp("R3 imm and sext", 6'h01, 32'hFFFF_0000, 32'h0, 1'b1, 13'h1000, 32'hFFFF_0000, curF);
  endtask

  task automatic testLogicFlags();
    runOp("R4 set V and C", 6'h10, 32'h8000_0000, 32'h8000_0000, 1'b0, '0, 32'h0, 4'b0111);
    runOp("R6 andcc clears VC", 6'h11, 32'hF0, 32'h0F, 1'b0, '0, 32'h0, 4'b0100);
    runOp("R4 set V and C again", 6'h10, 32'h8000_0000, 32'h8000_0000, 1'b0, '0, 32'h0, 4'b0111);
    runOp("R6 orncc negative", 6'h16, 32'h0, 32'h0, 1'b0, '0, 32'hFFFF_FFFF, 4'b1000);
    runOp("R6 xnorcc", 6'h17, 32'd5, 32'd5, 1'b0, '0, 32'hFFFF_FFFF, 4'b1000);
    runOp("R6 andncc zero", 6'h15, 32'hF, 32'hF, 1'b0, '0, 32'h0, 4'b0100);
    runOp("R2 orcc", 6'h12, 32'h1, 32'h2, 1'b0, '0, 32'h3, 4'b0000);
    runOp("R2 xorcc", 6'h13, 32'h8000_0001, 32'h1, 1'b0, '0, 32'h8000_0000, 4'b1000);
  endtask

  task automatic testShifts();
    runOp("R8 sll low5 count", 6'h25, 32'h1, 32'h23, 1'b0, '0, 32'h8, curF);
    runOp("R8 srl by 31", 6'h26, 32'h8000_0000, 32'd31, 1'b0, '0, 32'h1, curF);
    runOp("R8 sra negative", 6'h27, 32'h8000_0000, 32'd4, 1'b0, '0, 32'hF800_0000, curF);
    runOp("R8 sra positive imm", 6'h27, 32'h4000_0000, 32'h0, 1'b1, 13'd4, 32'h0400_0000, curF);
    runOp("R8 sra low5 count", 6'h27, 32'h8000_0010, 32'h24, 1'b0, '0, 32'hF800_0001, curF);
  endtask

  task automatic testIllegal();
    logic [5:0] bad [8] = '{6'h09, 6'h0F, 6'h19, 6'h1F, 6'h20, 6'h24, 6'h28, 6'h3F};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      opValid = 1'b1; opCode = bad[i]; opA = 32'h0; regB = 32'h0; immSel = 1'b0;
      #5;
      chk("R9 illegalOp raised", {31'b0, illegalOp}, 32'h1);
      @(negedge clk);
      opValid = 1'b0;
      #1;
      chk("R11 illegalOp drops with valid", {31'b0, illegalOp}, 32'h0);
      chk("R9 flags unchanged", {28'b0, flagN, flagZ, flagV, flagC}, {28'b0, curF});
    end
  endtask

  task automatic testInvalid();
    @(negedge clk);
    opValid = 1'b0; opCode = 6'h14; opA = 32'h0; regB = 32'h0; immSel = 1'b0;
    #5;
    chk("R11 no illegal when invalid", {31'b0, illegalOp}, 32'h0);
    @(negedge clk);
    chk("R10 invalid cc op keeps flags", {28'b0, flagN, flagZ, flagV, flagC}, {28'b0, curF});
    opCode = 6'h3F;
    #5;
    chk("R11 bad code invalid", {31'b0, illegalOp}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testLogicPlain();
    testAddFlags();
    testAddx();
    testSubFlags();
    testImm();
    testLogicFlags();
    testShifts();
    testIllegal();
    testInvalid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule